// File: doc/BRIEF.md
# Bit-Serial Sector CRC-16 Generator

This block produces a 16-bit check value over one sector of exactly 32 sixteen-bit words. Words are offered one at a time on a valid/ready stream. A start-of-sector strobe clears the running check value and the word count. Each accepted word is then folded into the CRC one bit per clock, least-significant bit first. The update is the reflected form with polynomial constant 0xA001: the data bit is XORed into CRC bit 0, the CRC shifts right, and if the bit shifted out was 1 the constant is XORed in.

When the sixteenth bit of the thirty-second word has been folded in, the block shows the finished CRC on its result port with a one-cycle done pulse. It keeps that value until the next start strobe and refuses further words until then. A reader of several sectors strobes start before each one, so the value left on the port belongs to the last sector processed.

Top module: `sector_crc16`

## Requirements
- R1: While reset is asserted, and until the first word is accepted after reset, in_ready is 1, done_o is 0 and crc_o is 0x0000. Reset acts as a start strobe.
- R2: A word is taken on a clock edge where in_valid and in_ready are both 1. in_ready is then 0 for exactly the 16 following cycles, and it returns to 1 afterwards unless the sector is complete.
- R3: The CRC starts at 0x0000. Each of a word's 16 bits, bit 0 first, is folded in as one step: feedback = crc[0] XOR data bit; crc = crc >> 1; if the feedback is 1, crc = crc XOR 0xA001.
- R4: The cycle after the 16th step of the 32nd word, done_o is 1 for exactly one cycle. In that same cycle crc_o shows the CRC of all 32 words.
- R5: crc_o changes only to the final value in the done cycle, or to 0x0000 in the cycle after a start strobe. It reads 0x0000 between a start strobe and the next done pulse.
- R6: After the sector completes, in_ready stays 0 and words offered on in_valid are ignored: crc_o and done_o do not change until the next start strobe.
- R7: A start strobe (sos_i = 1 at a clock edge) clears the CRC and the word count. In the next cycle crc_o is 0x0000, done_o is 0 and in_ready is 1, unless a word was accepted at the same edge.
- R8: A start strobe during the 16 shift cycles of a word abandons that word. It contributes nothing, and the following 32 words form a sector whose CRC excludes it.
- R9: If a start strobe and a word acceptance fall on the same edge, that word becomes the first word of the new sector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sos_i | input | 1 | Start-of-sector strobe, one cycle |
| in_valid | input | 1 | Data word offered |
| in_data | input | 16 | Data word |
| in_ready | output | 1 | Block can take a word this cycle |
| crc_o | output | 16 | Held sector CRC result |
| done_o | output | 1 | One-cycle pulse when crc_o becomes valid |

## Verification
The start strobe can meet either of two other actions on the same edge: the acceptance of a word, or a shift step in the middle of a word. The bench drives sos_i together with in_valid while in_ready is high, so that the taken word must open the new sector. It also raises sos_i a few cycles into a word's shifting, so that the partial word must disappear. In both cases a behavioural reference model that steps once per clock gives the expected in_ready, done_o and crc_o, and the final CRC is also computed independently from the words that make up the sector.

// File: rtl/scrc_pkg.sv
package scrc_pkg;
  localparam int unsigned SCRC_WORD_W   = 16;
  localparam int unsigned SCRC_SECTOR_N = 32;
  localparam logic [15:0] SCRC_POLY     = 16'hA001;
  localparam logic [15:0] SCRC_INIT     = 16'h0000;
endpackage

// File: rtl/scrc_rst_sync.sv
module scrc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/scrc_seq.sv
module scrc_seq #(
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned SECTOR_WORDS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic valid_i,
  output logic ready_o,
  output logic accept_o,
  output logic step_o,
  output logic last_o
);
  localparam int unsigned BIT_CNT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int unsigned WORD_CNT_W = (SECTOR_WORDS > 1) ? $clog2(SECTOR_WORDS) : 1;
  localparam logic [BIT_CNT_W-1:0]  LAST_BIT  = BIT_CNT_W'(WORD_W - 1);
  localparam logic [WORD_CNT_W-1:0] LAST_WORD = WORD_CNT_W'(SECTOR_WORDS - 1);

  logic                  busy_q, busy_d;
  logic                  full_q, full_d;
  logic [BIT_CNT_W-1:0]  bit_q, bit_d;
  logic [WORD_CNT_W-1:0] word_q, word_d;
  logic                  word_end;

  assign ready_o  = !busy_q && !full_q;
  assign accept_o = valid_i && ready_o;
  assign step_o   = busy_q && !start_i;
  assign word_end = step_o && (bit_q == LAST_BIT);
  assign last_o   = word_end && (word_q == LAST_WORD);

  always_comb begin
    busy_d = busy_q;
    full_d = full_q;
    bit_d  = bit_q;
    word_d = word_q;
    if (start_i) begin
      busy_d = 1'b0;
      full_d = 1'b0;
      bit_d  = '0;
      word_d = '0;
    end else if (busy_q) begin
      bit_d = bit_q + 1'b1;
      if (word_end) begin
        busy_d = 1'b0;
        bit_d  = '0;
        if (last_o) begin
          full_d = 1'b1;
          word_d = '0;
        end else begin
          word_d = word_q + 1'b1;
        end
      end
    end
    if (accept_o) begin
      busy_d = 1'b1;
      bit_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      full_q <= 1'b0;
      bit_q  <= '0;
      word_q <= '0;
    end else begin
      busy_q <= busy_d;
      full_q <= full_d;
      bit_q  <= bit_d;
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/scrc_engine.sv
module scrc_engine #(
  parameter int unsigned     WORD_W = 16,
  parameter logic [15:0]     POLY   = 16'hA001,
  parameter logic [15:0]     INIT   = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              step_i,
  output logic [15:0]       crc_next_o
);
  localparam int unsigned CRC_W = 16;

  logic [CRC_W-1:0]  crc_q, crc_d;
  logic [WORD_W-1:0] dat_q, dat_d;
  logic              fb;
  logic [CRC_W-1:0]  stepped;

  assign fb = crc_q[0] ^ dat_q[0];

  for (genvar i = 0; i < CRC_W; i++) begin : g_tap
    if (i == CRC_W - 1) begin : g_top
      assign stepped[i] = fb & POLY[i];
    end else begin : g_mid
      assign stepped[i] = crc_q[i+1] ^ (fb & POLY[i]);
    end
  end

  assign crc_next_o = stepped;

  always_comb begin
    crc_d = crc_q;
    dat_d = dat_q;
    if (clear_i) begin
      crc_d = INIT;
    end else if (step_i) begin
      crc_d = stepped;
      dat_d = dat_q >> 1;
    end
    if (load_i) dat_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
      dat_q <= '0;
    end else begin
      crc_q <= crc_d;
      dat_q <= dat_d;
    end
  end
endmodule

// File: rtl/scrc_result.sv
module scrc_result (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        capture_i,
  input  logic [15:0] value_i,
  output logic [15:0] result_o,
  output logic        done_o
);
  logic [15:0] res_q, res_d;
  logic        done_q, done_d;
  logic        res_en;

  assign res_en = start_i || capture_i;

  always_comb begin
    done_d = capture_i && !start_i;
    res_d  = start_i ? 16'h0000 : value_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= 16'h0000;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sector_crc16.sv
module sector_crc16 #(
  parameter int unsigned WORD_W       = scrc_pkg::SCRC_WORD_W,
  parameter int unsigned SECTOR_WORDS = scrc_pkg::SCRC_SECTOR_N,
  parameter logic [15:0] POLY         = scrc_pkg::SCRC_POLY,
  parameter logic [15:0] INIT         = scrc_pkg::SCRC_INIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sos_i,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic [15:0]       crc_o,
  output logic              done_o
);
  logic        rst_int_n;
  logic        accept;
  logic        step;
  logic        last;
  logic [15:0] crc_next;

  scrc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  scrc_seq #(
    .WORD_W       (WORD_W),
    .SECTOR_WORDS (SECTOR_WORDS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (sos_i),
    .valid_i  (in_valid),
    .ready_o  (in_ready),
    .accept_o (accept),
    .step_o   (step),
    .last_o   (last)
  );

  scrc_engine #(
    .WORD_W (WORD_W),
    .POLY   (POLY),
    .INIT   (INIT)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear_i    (sos_i),
    .load_i     (accept),
    .data_i     (in_data),
    .step_i     (step),
    .crc_next_o (crc_next)
  );

  scrc_result u_res (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (sos_i),
    .capture_i (last),
    .value_i   (crc_next),
    .result_o  (crc_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/sector_crc16_chk.sv
module sector_crc16_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sos_i,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] crc_o,
  input logic        done_o
);
  logic       armed_q;
  logic [7:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      low_cnt_q <= '0;
    end else if (sos_i) begin
      armed_q   <= 1'b0;
      low_cnt_q <= '0;
    end else if (in_valid && in_ready) begin
      armed_q   <= 1'b1;
      low_cnt_q <= '0;
    end else if (armed_q && !in_ready) begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end else if (in_ready) begin
      armed_q <= 1'b0;
    end
  end

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  busy_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && in_ready) |-> (low_cnt_q == 8'(WORD_W)));

  // R4
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  result_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sos_i |=> (done_o || $stable(crc_o)));

  // R6
  done_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !in_ready);

  // R7
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sos_i |=> (crc_o == 16'h0000 && !done_o));
endmodule

bind sector_crc16 sector_crc16_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sos_i    (sos_i),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .crc_o    (crc_o),
  .done_o   (done_o)
);

// File: tb/sector_crc16_bench.sv
`timescale 1ns/1ps
module sector_crc16_bench;
  logic        clk;
  logic        rst_n;
  logic        sos_i;
  logic        in_valid;
  logic [15:0] in_data;
  logic        in_ready;
  logic [15:0] crc_o;
  logic        done_o;

  int checks;
  int fails;

  logic [15:0] sec [32];

  // reference model state
  logic        m_busy, m_full, m_done;
  int          m_bits, m_words;
  logic [15:0] m_crc, m_dat, m_res;
  bit          cmp_en;

  sector_crc16 u_sector_crc16 (
    .clk      (clk),
    .rst_n    (rst_n),
    .sos_i    (sos_i),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .crc_o    (crc_o),
    .done_o   (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ref_crc();
    logic [15:0] c = 16'h0000;
    for (int w = 0; w < 32; w++) begin
      for (int b = 0; b < 16; b++) begin
        logic f = c[0] ^ sec[w][b];
        c = c >> 1;
        if (f) c = c ^ 16'hA001;
      end
    end
    return c;
  endfunction

  // cycle-by-cycle model and comparison
  always @(posedge clk) begin
    logic acc;
    logic f;
    if (!rst_n) begin
      m_busy = 0; m_full = 0; m_done = 0; m_bits = 0; m_words = 0;
      m_crc = 0; m_dat = 0; m_res = 0;
    end else begin
      acc = in_valid && !m_busy && !m_full;
      m_done = 0;
      if (sos_i) begin
        m_busy = 0; m_full = 0; m_words = 0; m_bits = 0; m_crc = 0; m_res = 0;
      end else if (m_busy) begin
        f = m_crc[0] ^ m_dat[0];
        m_crc = m_crc >> 1;
        if (f) m_crc = m_crc ^ 16'hA001;
        m_dat = m_dat >> 1;
        m_bits++;
        if (m_bits == 16) begin
          m_busy = 0;
          m_bits = 0;
          m_words++;
          if (m_words == 32) begin
            m_full = 1; m_words = 0; m_res = m_crc; m_done = 1;
          end
        end
      end
      if (acc) begin
        m_busy = 1; m_bits = 0; m_dat = in_data;
      end
    end
    #2;
    if (cmp_en) begin
      chk(in_ready == (!m_busy && !m_full), "R2/R6 in_ready vs model", {15'd0, in_ready}, {15'd0, !m_busy && !m_full});
      chk(crc_o == m_res, "R3/R5 crc_o vs model", crc_o, m_res);
      chk(done_o == m_done, "R4 done_o vs model", {15'd0, done_o}, {15'd0, m_done});
    end
  end

  task automatic send_word(input logic [15:0] d, input bit with_sos);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    sos_i    = with_sos;
    @(negedge clk);
    in_valid = 1'b0;
    sos_i    = 1'b0;
  endtask

  task automatic pulse_sos();
    @(negedge clk);
    sos_i = 1'b1;
    @(negedge clk);
    sos_i = 1'b0;
  endtask

  task automatic run_sector(input string tag, input bit first_sos);
    logic [15:0] exp;
    int guard;
    exp = ref_crc();
    for (int i = 0; i < 32; i++) send_word(sec[i], first_sos && (i == 0));
    guard = 0;
    while (!done_o && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    chk(done_o === 1'b1, {tag, " R4 done seen"}, {15'd0, done_o}, 16'h0001);
    chk(crc_o == exp, {tag, " R3 final crc"}, crc_o, exp);
    @(negedge clk);
    chk(done_o === 1'b0, {tag, " R4 done one cycle"}, {15'd0, done_o}, 16'h0000);
    repeat (5) @(negedge clk);
    chk(crc_o == exp, {tag, " R5 result held"}, crc_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    checks = 0; fails = 0; cmp_en = 0;
    rst_n = 1'b0; sos_i = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && done_o === 1'b0 && crc_o === 16'h0000, "R1 reset state",
        crc_o, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1;
    chk(in_ready === 1'b1 && crc_o === 16'h0000, "R1 after release", crc_o, 16'h0000);

    // all-zero sector
    for (int i = 0; i < 32; i++) sec[i] = 16'h0000;
    pulse_sos();
    run_sector("zero", 0);
    chk(crc_o == 16'h0000, "R3 zero sector crc", crc_o, 16'h0000);

    // R6: words offered after completion are ignored
    held = crc_o;
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'hBEEF;
    repeat (20) @(negedge clk);
    chk(in_ready === 1'b0, "R6 ready low after sector", {15'd0, in_ready}, 16'h0000);
    chk(crc_o == held && done_o === 1'b0, "R6 result untouched", crc_o, held);
    in_valid = 1'b0;

    // R7: start clears
    pulse_sos();
    chk(in_ready === 1'b1 && crc_o == 16'h0000, "R7 start clears", crc_o, 16'h0000);

    // all-ones sector
    for (int i = 0; i < 32; i++) sec[i] = 16'hFFFF;
    run_sector("ones", 0);

    // random sectors
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 32; i++) sec[i] = 16'($urandom);
      pulse_sos();
      chk(crc_o == 16'h0000, "R5 zero before done", crc_o, 16'h0000);
      run_sector("random", 0);
    end

    // R8: start during shifting abandons the word
    pulse_sos();
    send_word(16'h1234, 0);
    repeat (4) @(negedge clk);
    chk(in_ready === 1'b0, "R2 busy during shift", {15'd0, in_ready}, 16'h0000);
    pulse_sos();
    chk(in_ready === 1'b1 && crc_o == 16'h0000, "R8 abort restores ready", crc_o, 16'h0000);
    for (int i = 0; i < 32; i++) sec[i] = 16'($urandom);
    run_sector("R8 abort", 0);

    // R9: start and acceptance on the same edge, mid sector
    pulse_sos();
    for (int i = 0; i < 5; i++) send_word(16'($urandom), 0);
    for (int i = 0; i < 32; i++) sec[i] = 16'($urandom);
    run_sector("R9 coincident", 1);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule